// File: doc/BRIEF.md
# Display Field Completion Tracker

This block follows a video display through its fields and frames. It keeps a pixel counter and a line counter that advance on qualified pixel clocks and restart at each line and field boundary. It compares the position against a programmed width and height. When the last programmed pixel of the last programmed line of a tracked field arrives, it raises a sticky done flag for that field, or for the frame in frame mode. It also raises a summary display-complete flag, which drives an interrupt when enabled.

Software acknowledges each flag by writing 1 to its clear bit. In continuous mode, completions simply recur field after field. In non-continuous mode, display still carries on into the next field. If a tracked completion arrives while an earlier done flag has not yet been acknowledged, a separate not-acknowledged error flag is raised. There is no streaming data path; every pin is a plain control or status signal sampled on the rising clock edge.

Top module: `dfc_tracker`

## Requirements
- R1: After reset, all five status bits and the interrupt output are 0.
- R2: The first enabled pixel of a field (field_start high) is line 1, pixel 1. An enabled pixel with line_start high moves to the next line at pixel 1. Any other enabled pixel advances the pixel count. A tracked field completes on the enabled pixel where the count first becomes line == height and pixel == width. Its flag reads as set in the cycle after that pixel. A field whose line count never reaches height, or whose last line never reaches width, sets no flag.
- R3: In field mode, a completion in a field with field_id 0 sets status bit 0 only if sel_f1 is high. A completion with field_id 1 sets status bit 1 only if sel_f2 is high. An unselected field changes no status bit.
- R4: In frame mode, field_id is ignored, and every completion sets status bit 2.
- R5: Status bit 3 (display complete) is set together with any of bits 0 to 2.
- R6: irq is high exactly when status bit 3 is set and irq_en is high.
- R7: Status bits are sticky. Writing 1 to sts_clr bit k clears status bit k. A set in the same cycle wins over the clear.
- R8: When cont_mode is low, a completion that arrives while any of status bits 0 to 2 is set also sets status bit 4 (not acknowledged). When cont_mode is high, bit 4 is never set.
- R9: With half_rate high, the pixel count advances on every second enabled pixel of a line, so count W is reached on pixel 2W-1.
- R10: Tracking begins only after disp_en is high, at the first field start that is a frame start. A frame start is field_id 0 in field mode, or any field start in frame mode. While disp_en is low, no completion is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Display enable |
| pix_en | input | 1 | Pixel clock enable, one pixel per high cycle |
| field_start | input | 1 | Current enabled pixel is the first of a field |
| line_start | input | 1 | Current enabled pixel is the first of a new line |
| field_id | input | 1 | Field identity, 0 = first, 1 = second |
| width | input | CNT_W | Programmed pixels per line |
| height | input | CNT_W | Programmed lines per field |
| cont_mode | input | 1 | Continuous display mode |
| frame_mode | input | 1 | Track whole frames instead of fields |
| sel_f1 | input | 1 | Track field 1 in field mode |
| sel_f2 | input | 1 | Track field 2 in field mode |
| half_rate | input | 1 | Pixel count advances every second pixel |
| irq_en | input | 1 | Display-complete interrupt enable |
| sts_clr | input | STS_W | Write-1-to-clear strobes per status bit |
| sts | output | STS_W | Status: 0 f1 done, 1 f2 done, 2 frame done, 3 complete, 4 not acknowledged |
| irq | output | 1 | Interrupt |

## Verification
A counter that drifts by even one count shows as a done flag that is missing, or that appears on the wrong field, one cycle after that field's last pixel. The bench therefore drives fields that are one column or one line short as well as exact and overlong ones. A sticky bit that drops without a clear, or a clear that beats a same-cycle set, shows at the very next status sample. A wrong acknowledgement check shows as a spurious or missing error bit at the second completion of a non-continuous sequence.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int STS_W    = 5;
  localparam int B_F1     = 0;
  localparam int B_F2     = 1;
  localparam int B_FRM    = 2;
  localparam int B_CMPL   = 3;
  localparam int B_NACK   = 4;
endpackage

// File: rtl/dfc_pos_counter.sv
module dfc_pos_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             field_start,
  input  logic             line_start,
  input  logic             half_rate,
  output logic [CNT_W-1:0] nxt_pix,
  output logic [CNT_W-1:0] nxt_line,
  output logic             step
);
  logic [CNT_W-1:0] pix_q, line_q;
  logic             ph_q, nxt_ph;

  always_comb begin
    nxt_pix  = pix_q;
    nxt_line = line_q;
    nxt_ph   = ph_q;
    step     = 1'b0;
    if (pix_en) begin
      if (field_start) begin
        nxt_line = CNT_W'(1);
        nxt_pix  = CNT_W'(1);
        nxt_ph   = 1'b0;
        step     = 1'b1;
      end else if (line_start) begin
        nxt_line = line_q + CNT_W'(1);
        nxt_pix  = CNT_W'(1);
        nxt_ph   = 1'b0;
        step     = 1'b1;
      end else if (half_rate && !ph_q) begin
        nxt_ph = 1'b1;
      end else begin
        nxt_pix = pix_q + CNT_W'(1);
        nxt_ph  = 1'b0;
        step    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
      ph_q   <= 1'b0;
    end else begin
      pix_q  <= nxt_pix;
      line_q <= nxt_line;
      ph_q   <= nxt_ph;
    end
  end
endmodule

// File: rtl/dfc_sticky_bank.sv
module dfc_sticky_bank #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[k] <= 1'b0;
      else if (set[k]) q[k] <= 1'b1;
      else if (clr[k]) q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/dfc_tracker.sv
module dfc_tracker
  import dfc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_en,
  input  logic             pix_en,
  input  logic             field_start,
  input  logic             line_start,
  input  logic             field_id,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] height,
  input  logic             cont_mode,
  input  logic             frame_mode,
  input  logic             sel_f1,
  input  logic             sel_f2,
  input  logic             half_rate,
  input  logic             irq_en,
  input  logic [STS_W-1:0] sts_clr,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic [CNT_W-1:0] nxt_pix, nxt_line;
  logic             step;
  logic             active_q, fid_q;
  logic             start_ok, act_now, cur_fid, evt, any_done;
  logic [STS_W-1:0] set_v;

  dfc_pos_counter #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .field_start(field_start), .line_start(line_start),
    .half_rate(half_rate), .nxt_pix(nxt_pix), .nxt_line(nxt_line),
    .step(step)
  );

  assign start_ok = pix_en && field_start && (frame_mode || !field_id);
  assign act_now  = disp_en && (active_q || start_ok);
  assign cur_fid  = (pix_en && field_start) ? field_id : fid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fid_q    <= 1'b0;
    end else begin
      if (!disp_en)      active_q <= 1'b0;
      else if (start_ok) active_q <= 1'b1;
      if (pix_en && field_start) fid_q <= field_id;
    end
  end

  assign evt      = act_now && step && (nxt_line == height) && (nxt_pix == width);
  assign any_done = sts[B_F1] | sts[B_F2] | sts[B_FRM];

  always_comb begin
    set_v          = '0;
    set_v[B_F1]    = evt && !frame_mode && !cur_fid && sel_f1;
    set_v[B_F2]    = evt && !frame_mode &&  cur_fid && sel_f2;
    set_v[B_FRM]   = evt &&  frame_mode;
    set_v[B_CMPL]  = set_v[B_F1] | set_v[B_F2] | set_v[B_FRM];
    set_v[B_NACK]  = set_v[B_CMPL] && !cont_mode && any_done;
  end

  dfc_sticky_bank #(.W(STS_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(set_v), .clr(sts_clr), .q(sts)
  );

  assign irq = sts[B_CMPL] && irq_en;
endmodule

// File: rtl/dfc_tracker_chk.sv
module dfc_tracker_chk #(
  parameter int STS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_en,
  input logic             cont_mode,
  input logic             irq_en,
  input logic [STS_W-1:0] sts_clr,
  input logic [STS_W-1:0] sts,
  input logic             irq
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (sts == '0 && !irq);
    end
  end

  p_done_sets_cmpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts[2:0] & ~$past(sts[2:0])) != 3'b000) |-> sts[3]);

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(sts) & ~$past(sts_clr))) & ~sts) == '0));

  p_cont_no_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_mode && !sts[4]) |=> !sts[4]);

  p_idle_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> ((sts[2:0] & ~$past(sts[2:0])) == 3'b000));
endmodule

bind dfc_tracker dfc_tracker_chk #(.STS_W(dfc_pkg::STS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .cont_mode(cont_mode),
  .irq_en(irq_en), .sts_clr(sts_clr), .sts(sts), .irq(irq)
);

// File: tb/sim_dfc_tracker.sv
module sim_dfc_tracker;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_en = 0, pix_en = 0, field_start = 0, line_start = 0, field_id = 0;
  logic [CW-1:0] width = CW'(4), height = CW'(3);
  logic cont_mode = 1, frame_mode = 0, sel_f1 = 1, sel_f2 = 1, half_rate = 0, irq_en = 1;
  logic [4:0] sts_clr = '0;
  logic [4:0] sts;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0] s;
    logic       i;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  dfc_tracker #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .pix_en(pix_en),
    .field_start(field_start), .line_start(line_start), .field_id(field_id),
    .width(width), .height(height), .cont_mode(cont_mode),
    .frame_mode(frame_mode), .sel_f1(sel_f1), .sel_f2(sel_f2),
    .half_rate(half_rate), .irq_en(irq_en), .sts_clr(sts_clr),
    .sts(sts), .irq(irq)
  );

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (sts !== e.s || irq !== e.i) begin
        n_bad++;
        $display("FAIL %s: sts=%b irq=%b expected sts=%b irq=%b", e.tag, sts, irq, e.s, e.i);
      end
    end
  end

  task automatic expect_st(input logic [4:0] s, input logic i, input string tag);
    exp_t e;
    e.s = s; e.i = i; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drive_field(input logic fid, input int nl, input int ppl,
                             input logic [4:0] clr_last);
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < ppl; p++) begin
        pix_en      = 1'b1;
        field_id    = fid;
        field_start = (l == 0 && p == 0);
        line_start  = (l > 0 && p == 0);
        sts_clr     = (l == nl-1 && p == ppl-1) ? clr_last : 5'b0;
        @(negedge clk);
      end
    end
    pix_en = 0; field_start = 0; line_start = 0; sts_clr = '0;
    @(negedge clk);
  endtask

  task automatic clear(input logic [4:0] m);
    sts_clr = m;
    @(negedge clk);
    sts_clr = '0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_st(5'b00000, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R10: disabled display records nothing
    drive_field(1'b0, 3, 4, 5'b0);
    expect_st(5'b00000, 1'b0, "R10 disp_en low");
    disp_en = 1'b1;
    drive_field(1'b1, 3, 4, 5'b0);
    expect_st(5'b00000, 1'b0, "R10 wait for frame start");
    // R2: short field (two of three lines)
    drive_field(1'b0, 2, 4, 5'b0);
    expect_st(5'b00000, 1'b0, "R2 short field");
    // R2 R3 R5 R6: field 1 complete
    drive_field(1'b0, 3, 4, 5'b0);
    expect_st(5'b01001, 1'b1, "R3 field1 done with R5 R6");
    // R3 R8: field 2 in continuous mode
    drive_field(1'b1, 3, 4, 5'b0);
    expect_st(5'b01011, 1'b1, "R8 continuous no nack, R3 field2");
    irq_en = 1'b0;
    expect_st(5'b01011, 1'b0, "R6 irq disabled");
    irq_en = 1'b1;
    clear(5'b11111);
    expect_st(5'b00000, 1'b0, "R7 write one clear");
    // R7: set wins over same-cycle clear
    drive_field(1'b0, 3, 4, 5'b01001);
    expect_st(5'b01001, 1'b1, "R7 set over clear");
    clear(5'b00001);
    expect_st(5'b01000, 1'b1, "R7 partial clear");
    clear(5'b11111);
    // R2: overlong last line still completes once
    drive_field(1'b1, 3, 6, 5'b0);
    expect_st(5'b01010, 1'b1, "R2 overlong line");
    clear(5'b11111);
    // R2: one column short
    drive_field(1'b0, 3, 3, 5'b0);
    expect_st(5'b00000, 1'b0, "R2 narrow field");
    // R3: unselected field 2
    sel_f2 = 1'b0;
    drive_field(1'b1, 3, 4, 5'b0);
    expect_st(5'b00000, 1'b0, "R3 unselected field");
    sel_f2 = 1'b1;
    // R8: non-continuous without acknowledgement
    cont_mode = 1'b0;
    drive_field(1'b0, 3, 4, 5'b0);
    expect_st(5'b01001, 1'b1, "R8 first completion");
    drive_field(1'b1, 3, 4, 5'b0);
    expect_st(5'b11011, 1'b1, "R8 nack raised");
    clear(5'b11111);
    drive_field(1'b0, 3, 4, 5'b0);
    clear(5'b01001);
    drive_field(1'b1, 3, 4, 5'b0);
    expect_st(5'b01010, 1'b1, "R8 acknowledged in time");
    clear(5'b11111);
    cont_mode = 1'b1;
    // R9: half rate
    half_rate = 1'b1;
    drive_field(1'b0, 3, 6, 5'b0);
    expect_st(5'b00000, 1'b0, "R9 half rate 6 pixels short");
    drive_field(1'b0, 3, 7, 5'b0);
    expect_st(5'b01001, 1'b1, "R9 half rate 7 pixels");
    half_rate = 1'b0;
    clear(5'b11111);
    // R4: frame mode ignores field id; R10 restart in frame mode
    disp_en = 1'b0;
    @(negedge clk);
    disp_en = 1'b1;
    frame_mode = 1'b1;
    drive_field(1'b1, 3, 4, 5'b0);
    expect_st(5'b01100, 1'b1, "R4 frame done, R10 frame start");
    expect_st(5'b01100, 1'b1, "R7 sticky hold");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule